// File: doc/BRIEF.md
# Configuration Image Revision Picker

This block decides which of up to four stored configuration images a configuration memory streams out. The revision code comes either from two external select pins or from two internally programmed select bits, and a source-select input chooses between them. The code is not followed continuously: it is captured only when a defined event occurs. These events are the first clock after power-on reset, a rising edge of the active-low chip enable, a reset assertion on the output-enable/reset line while the chip is enabled, a release of the configuration-request line while the chip is enabled, and a configuration command from the test port.

Every capture produces three outputs. The first is the captured revision. The second is a byte start address for the data streamer, which the block takes from a table of per-revision start blocks, each block being 2^20 bytes. The third is a one-cycle load strobe that tells the streamer to reload its address counter. A revision whose table entry is not marked valid is replaced by revision 0.

The three asynchronous control lines pass through two-flop synchronisers before their edges are detected. The test-port command strobe is taken as already synchronous to the clock.

Top module: `revision_picker`

## Requirements
- R1: While `porRstN` is low, `activeRev` is 0, `startAddr` is 0 and `loadStrobe` is 0.
- R2: On the first rising clock edge after `porRstN` goes high, the selection is captured and `loadStrobe` is high for that one cycle.
- R3: When `useIntSel` is 0, the captured code is `pinRev`; when it is 1, the code is `intRev`. Codes 2'b00, 2'b01, 2'b10 and 2'b11 stand for revisions 0, 1, 2 and 3.
- R4: A 0-to-1 change on `chipEnN` causes a capture. Outputs update on the third rising clock edge after the change.
- R5: A 1-to-0 change on `outEnRstN` causes a capture on the third rising edge when `chipEnN` is low, and causes nothing when `chipEnN` is high. A 0-to-1 change causes nothing.
- R6: A 0-to-1 change on `cfgReqN` causes a capture on the third rising edge when `chipEnN` is low, and causes nothing when `chipEnN` is high. A 1-to-0 change causes nothing.
- R7: A one-cycle high on `jtagCfgStrobe` causes a capture on the next rising clock edge.
- R8: Between capture events, changes on `pinRev`, `intRev` and `useIntSel` leave `activeRev`, `startAddr` and `loadStrobe` unchanged.
- R9: `loadStrobe` is high for exactly one cycle per capture cycle. Events that fall on the same capture edge produce a single strobe.
- R10: After a capture of revision r, `startAddr` equals the table entry `startTable[r*BLK_W +: BLK_W]` shifted left by 20 bits (2^20-byte blocks), so its low 20 bits are zero.
- R11: If `revValid[r]` is 0 for the selected code r, revision 0 and the start address of revision 0 are captured instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| chipEnN | input | 1 | Chip enable, active low, asynchronous |
| outEnRstN | input | 1 | Output enable / reset line, low = reset, asynchronous |
| cfgReqN | input | 1 | Configuration-request line, active low, asynchronous |
| jtagCfgStrobe | input | 1 | One-cycle test-port configuration command, synchronous |
| useIntSel | input | 1 | 0 = external select pins, 1 = internal select bits |
| pinRev | input | 2 | External revision select pins |
| intRev | input | 2 | Internal programmed revision select bits |
| startTable | input | NUM_REVS*BLK_W | Start block of each revision, revision r at bits r*BLK_W upward |
| revValid | input | NUM_REVS | Bit r set when revision r holds a valid image |
| activeRev | output | 2 | Captured revision |
| startAddr | output | BLK_W+20 | Byte start address of the captured revision |
| loadStrobe | output | 1 | One-cycle pulse after every capture |

## Verification
A chip-enable rising edge and a test-port command can reach the capture logic in the same cycle. The bench provokes this by raising `chipEnN` and then pulsing `jtagCfgStrobe` two clock edges later, so both events land on the third edge after the enable change. It then expects exactly one `loadStrobe` cycle, carrying the currently selected revision, followed by several cycles with no strobe. Ignored edges on the output-enable and request lines while the chip is disabled are judged separately: the bench watches `loadStrobe` and `activeRev` over the cycles in which a capture would otherwise have appeared.

// File: rtl/revision_picker_pkg.sv
package revision_picker_pkg;
  // strobes the control half hands to the datapath half
  typedef struct packed {
    logic sampleNow;
  } pickStrobes_t;
endpackage

// File: rtl/revision_picker_ctrl.sv
module revision_picker_ctrl
  import revision_picker_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         porRstN,
  input  logic         chipEnN,
  input  logic         outEnRstN,
  input  logic         cfgReqN,
  input  logic         jtagCfgStrobe,
  output pickStrobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ceSync, oeSync, cfSync;
  logic          cePrev, oePrev, cfPrev;
  logic          powerUpPend;
  logic          ceHigh, ceRise, oeFall, cfRise;

  // synchronisers; idle level of every line is high
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      ceSync      <= '1;
      oeSync      <= '1;
      cfSync      <= '1;
      cePrev      <= 1'b1;
      oePrev      <= 1'b1;
      cfPrev      <= 1'b1;
      powerUpPend <= 1'b1;
    end else begin
      ceSync      <= {ceSync[LAST-1:0], chipEnN};
      oeSync      <= {oeSync[LAST-1:0], outEnRstN};
      cfSync      <= {cfSync[LAST-1:0], cfgReqN};
      cePrev      <= ceSync[LAST];
      oePrev      <= oeSync[LAST];
      cfPrev      <= cfSync[LAST];
      powerUpPend <= 1'b0;
    end
  end

  always_comb begin
    ceHigh = ceSync[LAST];
    ceRise = ceHigh & ~cePrev;
    oeFall = ~oeSync[LAST] & oePrev;
    cfRise = cfSync[LAST] & ~cfPrev;
    strobes.sampleNow = powerUpPend | ceRise | jtagCfgStrobe
                      | (~ceHigh & (oeFall | cfRise));
  end

  // R2: the power-up capture request never comes back
  p_pwrup_once_r2: assert property (@(posedge clk) disable iff (!porRstN)
    !powerUpPend |=> !powerUpPend);

endmodule

// File: rtl/revision_picker_dp.sv
module revision_picker_dp
  import revision_picker_pkg::*;
#(
  parameter int NUM_REVS  = 4,
  parameter int BLK_W     = 4,
  parameter int BLK_SHIFT = 20,
  localparam int REV_W    = $clog2(NUM_REVS),
  localparam int ADDR_W   = BLK_W + BLK_SHIFT
) (
  input  logic                      clk,
  input  logic                      porRstN,
  input  pickStrobes_t              strobes,
  input  logic                      useIntSel,
  input  logic [REV_W-1:0]          pinRev,
  input  logic [REV_W-1:0]          intRev,
  input  logic [NUM_REVS*BLK_W-1:0] startTable,
  input  logic [NUM_REVS-1:0]       revValid,
  output logic [REV_W-1:0]          activeRev,
  output logic [ADDR_W-1:0]         startAddr,
  output logic                      loadStrobe
);
  logic [BLK_W-1:0] blkOf [NUM_REVS];
  logic [REV_W-1:0] wantRev, chosenRev;

  for (genvar r = 0; r < NUM_REVS; r++) begin : g_tbl
    assign blkOf[r] = startTable[r*BLK_W +: BLK_W];
  end

  always_comb begin
    wantRev   = useIntSel ? intRev : pinRev;
    chosenRev = revValid[wantRev] ? wantRev : '0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      activeRev  <= '0;
      startAddr  <= '0;
      loadStrobe <= 1'b0;
    end else begin
      loadStrobe <= strobes.sampleNow;
      if (strobes.sampleNow) begin
        activeRev <= chosenRev;
        startAddr <= ADDR_W'(blkOf[chosenRev]) << BLK_SHIFT;
      end
    end
  end

  // R11: a captured revision is valid or the fallback
  p_fallback_r11: assert property (@(posedge clk) disable iff (!porRstN)
    loadStrobe |-> (activeRev == '0 || revValid[activeRev]));

  // R8: the revision only moves together with a load strobe
  p_rev_moves_on_load_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (activeRev != $past(activeRev)) |-> loadStrobe);

  // R10: address is block aligned and matches the table
  p_addr_table_r10: assert property (@(posedge clk) disable iff (!porRstN)
    loadStrobe |-> (startAddr[BLK_SHIFT-1:0] == '0 &&
                    startAddr[ADDR_W-1:BLK_SHIFT] == blkOf[activeRev]));

endmodule

// File: rtl/revision_picker.sv
module revision_picker
  import revision_picker_pkg::*;
#(
  parameter int NUM_REVS    = 4,
  parameter int BLK_W       = 4,
  parameter int BLK_SHIFT   = 20,
  parameter int SYNC_STAGES = 2,
  localparam int REV_W      = $clog2(NUM_REVS),
  localparam int ADDR_W     = BLK_W + BLK_SHIFT
) (
  input  logic                      clk,
  input  logic                      porRstN,
  input  logic                      chipEnN,
  input  logic                      outEnRstN,
  input  logic                      cfgReqN,
  input  logic                      jtagCfgStrobe,
  input  logic                      useIntSel,
  input  logic [REV_W-1:0]          pinRev,
  input  logic [REV_W-1:0]          intRev,
  input  logic [NUM_REVS*BLK_W-1:0] startTable,
  input  logic [NUM_REVS-1:0]       revValid,
  output logic [REV_W-1:0]          activeRev,
  output logic [ADDR_W-1:0]         startAddr,
  output logic                      loadStrobe
);
  pickStrobes_t strobes;

  revision_picker_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk          (clk),
    .porRstN      (porRstN),
    .chipEnN      (chipEnN),
    .outEnRstN    (outEnRstN),
    .cfgReqN      (cfgReqN),
    .jtagCfgStrobe(jtagCfgStrobe),
    .strobes      (strobes)
  );

  revision_picker_dp #(
    .NUM_REVS (NUM_REVS),
    .BLK_W    (BLK_W),
    .BLK_SHIFT(BLK_SHIFT)
  ) dp_i (
    .clk       (clk),
    .porRstN   (porRstN),
    .strobes   (strobes),
    .useIntSel (useIntSel),
    .pinRev    (pinRev),
    .intRev    (intRev),
    .startTable(startTable),
    .revValid  (revValid),
    .activeRev (activeRev),
    .startAddr (startAddr),
    .loadStrobe(loadStrobe)
  );

  // R9: every capture request yields a strobe next cycle
  p_load_follows_sample_r9: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.sampleNow |=> loadStrobe);

  // R9: no strobe without a capture request
  p_no_spurious_load_r9: assert property (@(posedge clk) disable iff (!porRstN)
    !strobes.sampleNow |=> !loadStrobe);

endmodule

// File: tb/revision_picker_tb_top.sv
`timescale 1ns/1ps
module revision_picker_tb_top;
  logic        clk = 1'b0;
  logic        porRstN, chipEnN, outEnRstN, cfgReqN, jtagCfgStrobe, useIntSel;
  logic [1:0]  pinRev, intRev;
  logic [15:0] startTable;
  logic [3:0]  revValid;
  logic [1:0]  activeRev;
  logic [23:0] startAddr;
  logic        loadStrobe;

  int checkCnt = 0;
  int passCnt  = 0;
  bit done     = 0;
  int tbl [4]  = '{0, 1, 3, 2};

  always #4 clk = ~clk;

  revision_picker dut_i (
    .clk(clk), .porRstN(porRstN), .chipEnN(chipEnN), .outEnRstN(outEnRstN),
    .cfgReqN(cfgReqN), .jtagCfgStrobe(jtagCfgStrobe), .useIntSel(useIntSel),
    .pinRev(pinRev), .intRev(intRev), .startTable(startTable),
    .revValid(revValid), .activeRev(activeRev), .startAddr(startAddr),
    .loadStrobe(loadStrobe)
  );

  function automatic int expAddr(input int r);
    return tbl[r] << 20;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic expectOut(input string tag, input int rev);
    chk(activeRev == rev, tag, "activeRev", activeRev, rev);
    chk(startAddr == expAddr(rev), tag, "startAddr", startAddr, expAddr(rev));
  endtask

  task automatic quiet(input int n, input string tag, input int rev);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(loadStrobe == 1'b0, tag, "no strobe", loadStrobe, 0);
    end
    expectOut(tag, rev);
  endtask

  // a synchronised line changed at the current falling edge
  task automatic edgePulse(input string tag, input int rev);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(loadStrobe == 1'b0, tag, "strobe early", loadStrobe, 0);
    @(negedge clk);
    chk(loadStrobe == 1'b1, tag, "strobe", loadStrobe, 1);
    expectOut(tag, rev);
    @(negedge clk);
    chk(loadStrobe == 1'b0, tag, "strobe width", loadStrobe, 0);
  endtask

  task automatic jtagPulse(input string tag, input int rev);
    @(negedge clk) jtagCfgStrobe = 1'b1;
    @(negedge clk) jtagCfgStrobe = 1'b0;
    chk(loadStrobe == 1'b1, tag, "strobe", loadStrobe, 1);
    expectOut(tag, rev);
    @(negedge clk);
    chk(loadStrobe == 1'b0, tag, "strobe width", loadStrobe, 0);
  endtask

  task automatic t_reset_powerup();
    repeat (3) @(negedge clk);
    chk(activeRev == 0, "R1", "activeRev", activeRev, 0);
    chk(startAddr == 0, "R1", "startAddr", startAddr, 0);
    chk(loadStrobe == 0, "R1", "loadStrobe", loadStrobe, 0);
    porRstN = 1'b1;
    @(negedge clk);
    chk(loadStrobe == 1'b1, "R2", "power-up strobe", loadStrobe, 1);
    expectOut("R3", 2);
    @(negedge clk);
    chk(loadStrobe == 1'b0, "R2", "strobe width", loadStrobe, 0);
  endtask

  task automatic t_hold_between_events();
    pinRev = 2'd3; intRev = 2'd0; useIntSel = 1'b1;
    quiet(4, "R8", 2);
    useIntSel = 1'b0;
    quiet(3, "R8", 2);
  endtask

  task automatic t_oe_fall_enabled();
    @(negedge clk) outEnRstN = 1'b0;
    edgePulse("R5", 3);
    outEnRstN = 1'b1;
    quiet(5, "R5", 3);
  endtask

  task automatic t_cfg_rise_enabled();
    pinRev = 2'd1;
    @(negedge clk) cfgReqN = 1'b0;
    quiet(5, "R6", 3);
    cfgReqN = 1'b1;
    edgePulse("R6", 1);
  endtask

  task automatic t_internal_jtag();
    useIntSel = 1'b1; intRev = 2'd0;
    jtagPulse("R7", 0);
    intRev = 2'd2;
    jtagPulse("R10", 2);
  endtask

  task automatic t_ce_rise();
    intRev = 2'd1;
    @(negedge clk) chipEnN = 1'b1;
    edgePulse("R4", 1);
  endtask

  task automatic t_ignored_when_disabled();
    intRev = 2'd3;
    @(negedge clk) outEnRstN = 1'b0;
    quiet(6, "R5", 1);
    outEnRstN = 1'b1;
    @(negedge clk) cfgReqN = 1'b0;
    quiet(4, "R6", 1);
    cfgReqN = 1'b1;
    quiet(6, "R6", 1);
  endtask

  task automatic t_fallback();
    revValid = 4'b0111; intRev = 2'd3;
    jtagPulse("R11", 0);
    revValid = 4'b1111;
    jtagPulse("R11", 3);
  endtask

  task automatic t_coincide();
    @(negedge clk) chipEnN = 1'b0;
    quiet(5, "R9", 3);
    intRev = 2'd1;
    @(negedge clk) chipEnN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) jtagCfgStrobe = 1'b1;
    @(negedge clk) jtagCfgStrobe = 1'b0;
    chk(loadStrobe == 1'b1, "R9", "merged strobe", loadStrobe, 1);
    expectOut("R9", 1);
    quiet(4, "R9", 1);
  endtask

  initial begin
    porRstN = 1'b0; chipEnN = 1'b0; outEnRstN = 1'b1; cfgReqN = 1'b1;
    jtagCfgStrobe = 1'b0; useIntSel = 1'b0; pinRev = 2'd2; intRev = 2'd1;
    startTable = {4'd2, 4'd3, 4'd1, 4'd0};
    revValid = 4'b1111;
    t_reset_powerup();
    t_hold_between_events();
    t_oe_fall_enabled();
    t_cfg_rise_enabled();
    t_internal_jtag();
    t_ce_rise();
    t_ignored_when_disabled();
    t_fallback();
    t_coincide();
    done = 1;
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, checkCnt);
      $finish;
    end
  end
endmodule